// File: doc/BRIEF.md
# Slave-Serial Configuration Loader

This block puts a target programmable device into configuration mode and streams a configuration image into it one bit at a time. A run begins with a one-cycle start pulse that also samples the image length. The loader then holds the target's active-low program line low for a set time and releases it. It waits for the target to release its active-low init line. It then takes image bytes over a valid/ready handshake and shifts each byte out on a data pin, toggling a configuration clock pin. The clock's high and low times are counted in system clock cycles.

After the last byte, or earlier if the byte source reports an error, the loader keeps issuing configuration clock pulses until the target raises done. Two separate limits guard the handshakes: one on how many cycles it waits for init, and one on how many pulses it gives while waiting for done. Each run ends with a one-cycle finish pulse and a two-bit status. Fetching and parsing the image happen outside the block.

Top module: `cfg_serial_loader`

## Requirements
- R1: After reset, and whenever no run is active, `prog_n_o` is 1, `cclk_o` is 0, `din_o` is 0 and `busy_o` is 0. After reset, `status_o` is 2'b00.
- R2: A start pulse seen while idle drives `prog_n_o` low for exactly `PROG_LOW_CYC` cycles before it returns high. `cclk_o` stays low while `prog_n_o` is low.
- R3: Every configuration clock pulse stays high for exactly `CCLK_HI_CYC` cycles. `din_o` only changes while `cclk_o` is low.
- R4: Image bytes are sent in the order they are accepted, most significant bit first. Each bit is on `din_o` before the rising edge of `cclk_o` that carries it.
- R5: A byte is accepted in a cycle where `byte_valid_i` and `byte_ready_o` are both 1. Exactly `img_len_i` bytes are accepted and shifted out, with 8 rising clock edges per byte.
- R6: If the synchronized `init_n_i` is still low after `INIT_POLL_MAX` polls, the run ends with `status_o` = 2'b01 and no configuration clock pulse is issued.
- R7: After the data phase, pulses are issued for as long as the synchronized `done_i` is low. Once it is seen high, the run ends with `status_o` = 2'b00.
- R8: If `done_i` stays low, exactly `DONE_PULSE_MAX` pulses follow the data phase and the run ends with `status_o` = 2'b10.
- R9: When `src_err_i` is high while the loader waits for a byte, no more bytes are accepted and the loader moves to done clocking. A byte that is already shifting completes first.
- R10: `finish_o` is high for exactly one cycle per run, in the first cycle in which `busy_o` is low. `status_o` changes only in that cycle.
- R11: A start pulse during a run is ignored. The run in progress is unchanged and finishes once.
- R12: An image length of zero skips the data phase and goes straight from the init handshake to done clocking.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a run |
| img_len_i | input | LEN_W | Number of image bytes, sampled with start |
| byte_valid_i | input | 1 | Image byte available |
| byte_data_i | input | BYTE_W | Image byte |
| src_err_i | input | 1 | Byte source failed; stop the data phase |
| byte_ready_o | output | 1 | Loader takes a byte this cycle if valid |
| prog_n_o | output | 1 | Active-low program line to the target |
| cclk_o | output | 1 | Configuration clock to the target |
| din_o | output | 1 | Serial configuration data to the target |
| init_n_i | input | 1 | Active-low init line from the target |
| done_i | input | 1 | Done line from the target |
| busy_o | output | 1 | Run in progress |
| finish_o | output | 1 | One-cycle pulse at the end of a run |
| status_o | output | 2 | 00 ok, 01 init timeout, 10 done timeout |

## Verification
A wrong sequencer state shows up at the pins within one bit period. Examples are a clock pulse during the program phase, a data edge while the clock is high, or a byte accepted after an error. A miscounted bit or byte index corrupts the serial stream that the bench reassembles, or changes the count of rising edges at the end of the run. A broken timeout counter shows up at the finish pulse, as a wrong status or a pulse count that differs from the limit.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

  typedef enum logic [1:0] {
    CFG_OK       = 2'b00,
    CFG_INIT_TMO = 2'b01,
    CFG_DONE_TMO = 2'b10
  } cfg_status_e;

  typedef enum logic [3:0] {
    SQ_IDLE,
    SQ_PROG,
    SQ_INIT,
    SQ_FETCH,
    SQ_BIT_LO,
    SQ_BIT_HI,
    SQ_DN_CHK,
    SQ_DN_HI,
    SQ_DN_LO
  } seq_state_e;

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) begin
        stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/cfg_tick_timer.sv
module cfg_tick_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] len_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i) begin
      cnt_d = len_i - 1'b1;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/cfg_limit_cnt.sv
module cfg_limit_cnt #(
  parameter int LIMIT = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic inc_i,
  output logic hit_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clear_i)                     cnt_d = '0;
    else if (inc_i && cnt_q != LIM_V) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign hit_o = (cnt_q == LIM_V);
endmodule

// File: rtl/cfg_bit_shifter.sv
module cfg_bit_shifter #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [BW-1:0] byte_i,
  input  logic          shift_i,
  output logic          msb_next_o,
  output logic          last_bit_o
);
  localparam int IW = (BW > 1) ? $clog2(BW) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(BW - 1);

  logic [BW-1:0] sh_q, sh_d;
  logic [IW-1:0] idx_q, idx_d;

  always_comb begin
    sh_d  = sh_q;
    idx_d = idx_q;
    if (load_i) begin
      sh_d  = byte_i;
      idx_d = '0;
    end else if (shift_i) begin
      sh_d  = {sh_q[BW-2:0], 1'b0};
      idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      idx_q <= '0;
    end else begin
      sh_q  <= sh_d;
      idx_q <= idx_d;
    end
  end

  assign msb_next_o = sh_d[BW-1];
  assign last_bit_o = (idx_q == LAST_IDX);
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
  import cfg_loader_pkg::*;
#(
  parameter int BYTE_W         = 8,
  parameter int LEN_W          = 24,
  parameter int PROG_LOW_CYC   = 50,
  parameter int CCLK_HI_CYC    = 1,
  parameter int CCLK_LO_CYC    = 1,
  parameter int INIT_POLL_MAX  = 100000,
  parameter int DONE_PULSE_MAX = 100000,
  parameter int SYNC_STAGES    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  img_len_i,
  input  logic              byte_valid_i,
  input  logic [BYTE_W-1:0] byte_data_i,
  input  logic              src_err_i,
  output logic              byte_ready_o,
  output logic              prog_n_o,
  output logic              cclk_o,
  output logic              din_o,
  input  logic              init_n_i,
  input  logic              done_i,
  output logic              busy_o,
  output logic              finish_o,
  output logic [1:0]        status_o
);
  localparam int MAX_HL  = (CCLK_HI_CYC > CCLK_LO_CYC) ? CCLK_HI_CYC : CCLK_LO_CYC;
  localparam int MAX_DLY = (PROG_LOW_CYC > MAX_HL) ? PROG_LOW_CYC : MAX_HL;
  localparam int TMR_W   = $clog2(MAX_DLY + 1);
  localparam logic [TMR_W-1:0] T_PROG = TMR_W'(PROG_LOW_CYC);
  localparam logic [TMR_W-1:0] T_HI   = TMR_W'(CCLK_HI_CYC);
  localparam logic [TMR_W-1:0] T_LO   = TMR_W'(CCLK_LO_CYC);

  seq_state_e  state_q, state_d;
  cfg_status_e status_q, status_d;
  logic [LEN_W-1:0] rem_q, rem_d;
  logic finish_q, finish_d;
  logic busy_q, prog_n_q, cclk_q, din_q;
  logic prog_n_d, cclk_d, din_d;

  logic tmr_load, tmr_exp;
  logic [TMR_W-1:0] tmr_len;
  logic poll_clr, poll_inc, poll_hit;
  logic pls_clr, pls_inc, pls_hit;
  logic sh_load, sh_shift, msb_next, last_bit;
  logic init_n_s, done_s;

  cfg_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_i({init_n_i, done_i}),
    .sync_o({init_n_s, done_s})
  );

  cfg_tick_timer #(.W(TMR_W)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .load_i(tmr_load), .len_i(tmr_len), .expired_o(tmr_exp)
  );

  cfg_limit_cnt #(.LIMIT(INIT_POLL_MAX)) u_init_lim (
    .clk(clk), .rst_n(rst_n),
    .clear_i(poll_clr), .inc_i(poll_inc), .hit_o(poll_hit)
  );

  cfg_limit_cnt #(.LIMIT(DONE_PULSE_MAX)) u_done_lim (
    .clk(clk), .rst_n(rst_n),
    .clear_i(pls_clr), .inc_i(pls_inc), .hit_o(pls_hit)
  );

  cfg_bit_shifter #(.BW(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .load_i(sh_load), .byte_i(byte_data_i), .shift_i(sh_shift),
    .msb_next_o(msb_next), .last_bit_o(last_bit)
  );

  assign byte_ready_o = (state_q == SQ_FETCH) && (rem_q != '0) && !src_err_i;

  // next-state process
  always_comb begin
    state_d  = state_q;
    status_d = status_q;
    rem_d    = rem_q;
    finish_d = 1'b0;
    tmr_load = 1'b0;
    tmr_len  = T_LO;
    poll_clr = 1'b0;
    poll_inc = 1'b0;
    pls_clr  = 1'b0;
    pls_inc  = 1'b0;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    unique case (state_q)
      SQ_IDLE: begin
        if (start_i) begin
          rem_d    = img_len_i;
          tmr_load = 1'b1;
          tmr_len  = T_PROG;
          state_d  = SQ_PROG;
        end
      end
      SQ_PROG: begin
        if (tmr_exp) begin
          poll_clr = 1'b1;
          state_d  = SQ_INIT;
        end
      end
      SQ_INIT: begin
        if (init_n_s) begin
          state_d = SQ_FETCH;
        end else if (poll_hit) begin
          status_d = CFG_INIT_TMO;
          finish_d = 1'b1;
          state_d  = SQ_IDLE;
        end else begin
          poll_inc = 1'b1;
        end
      end
      SQ_FETCH: begin
        if (rem_q == '0 || src_err_i) begin
          pls_clr = 1'b1;
          state_d = SQ_DN_CHK;
        end else if (byte_valid_i) begin
          sh_load  = 1'b1;
          rem_d    = rem_q - 1'b1;
          tmr_load = 1'b1;
          tmr_len  = T_LO;
          state_d  = SQ_BIT_LO;
        end
      end
      SQ_BIT_LO: begin
        if (tmr_exp) begin
          tmr_load = 1'b1;
          tmr_len  = T_HI;
          state_d  = SQ_BIT_HI;
        end
      end
      SQ_BIT_HI: begin
        if (tmr_exp) begin
          if (last_bit) begin
            state_d = SQ_FETCH;
          end else begin
            sh_shift = 1'b1;
            tmr_load = 1'b1;
            tmr_len  = T_LO;
            state_d  = SQ_BIT_LO;
          end
        end
      end
      SQ_DN_CHK: begin
        if (done_s) begin
          status_d = CFG_OK;
          finish_d = 1'b1;
          state_d  = SQ_IDLE;
        end else if (pls_hit) begin
          status_d = CFG_DONE_TMO;
          finish_d = 1'b1;
          state_d  = SQ_IDLE;
        end else begin
          pls_inc  = 1'b1;
          tmr_load = 1'b1;
          tmr_len  = T_HI;
          state_d  = SQ_DN_HI;
        end
      end
      SQ_DN_HI: begin
        if (tmr_exp) begin
          tmr_load = 1'b1;
          tmr_len  = T_LO;
          state_d  = SQ_DN_LO;
        end
      end
      SQ_DN_LO: begin
        if (tmr_exp) state_d = SQ_DN_CHK;
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  // pin values decoded from the next state so the pins change on a clock edge only
  always_comb begin
    prog_n_d = (state_d != SQ_PROG);
    cclk_d   = (state_d == SQ_BIT_HI) || (state_d == SQ_DN_HI);
    din_d    = ((state_d == SQ_BIT_LO) || (state_d == SQ_BIT_HI)) ? msb_next : 1'b0;
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SQ_IDLE;
      status_q <= CFG_OK;
      rem_q    <= '0;
      finish_q <= 1'b0;
      busy_q   <= 1'b0;
      prog_n_q <= 1'b1;
      cclk_q   <= 1'b0;
      din_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      status_q <= status_d;
      rem_q    <= rem_d;
      finish_q <= finish_d;
      busy_q   <= (state_d != SQ_IDLE);
      prog_n_q <= prog_n_d;
      cclk_q   <= cclk_d;
      din_q    <= din_d;
    end
  end

  assign prog_n_o = prog_n_q;
  assign cclk_o   = cclk_q;
  assign din_o    = din_q;
  assign busy_o   = busy_q;
  assign finish_o = finish_q;
  assign status_o = status_q;
endmodule

// File: rtl/cfg_serial_loader_chk.sv
module cfg_serial_loader_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy_o,
  input logic       finish_o,
  input logic [1:0] status_o,
  input logic       prog_n_o,
  input logic       cclk_o,
  input logic       din_o,
  input logic       byte_ready_o
);
  assert_idle_pins_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (prog_n_o && !cclk_o && !din_o));

  assert_no_clk_in_prog_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_n_o |-> !cclk_o);

  assert_din_hold_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cclk_o |-> $stable(din_o));

  assert_ready_in_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ready_o |-> (busy_o && prog_n_o && !cclk_o));

  assert_finish_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    finish_o |=> !finish_o);

  assert_finish_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    finish_o |-> !busy_o);

  assert_status_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !finish_o |-> $stable(status_o));

  assert_status_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    status_o != 2'b11);
endmodule

bind cfg_serial_loader cfg_serial_loader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .finish_o(finish_o),
  .status_o(status_o), .prog_n_o(prog_n_o), .cclk_o(cclk_o),
  .din_o(din_o), .byte_ready_o(byte_ready_o)
);

// File: tb/cfg_serial_loader_tb_top.sv
module cfg_serial_loader_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int P_PROG = 5;
  localparam int P_HI   = 2;
  localparam int P_LO   = 3;
  localparam int P_INIT = 40;
  localparam int P_DONE = 30;
  localparam int LW     = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic start, byte_valid, src_err, init_n, done;
  logic [LW-1:0] img_len;
  logic [7:0] byte_data;
  logic byte_ready, prog_n, cclk, din, busy, finish;
  logic [1:0] status;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_serial_loader #(
    .BYTE_W(8), .LEN_W(LW), .PROG_LOW_CYC(P_PROG), .CCLK_HI_CYC(P_HI),
    .CCLK_LO_CYC(P_LO), .INIT_POLL_MAX(P_INIT), .DONE_PULSE_MAX(P_DONE),
    .SYNC_STAGES(2)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .img_len_i(img_len),
    .byte_valid_i(byte_valid), .byte_data_i(byte_data), .src_err_i(src_err),
    .byte_ready_o(byte_ready), .prog_n_o(prog_n), .cclk_o(cclk), .din_o(din),
    .init_n_i(init_n), .done_i(done), .busy_o(busy), .finish_o(finish),
    .status_o(status)
  );

  int checks = 0;
  int errors = 0;

  // run configuration, written by the sequencing task
  int n_img = 0, err_at = -1, init_dly = -1, done_extra = -1, done_tgt = 0;
  bit mid_en = 0;
  logic [7:0] img [16];
  int go_req_n = 0;

  // run observations, written only by the negedge process
  int go_ack_n = 0, idx = 0, rise_cnt = 0, cap_n = 0, bitc = 0, fin_cnt = 0;
  int hi_run = 0, hi_bad = 0, low_run = 0, low_w = 0, busy_gap = 0, icnt = 0;
  int cyc = 0;
  bit pend = 0, seen_busy = 0, mid_done = 0, cclk_prev = 0, prog_prev = 1;
  logic [7:0] shreg = 0;
  logic [7:0] cap [16];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    start = 0; byte_valid = 0; byte_data = 0; src_err = 0;
    init_n = 0; done = 0; img_len = 0;
  end

  // stimulus drive, pin monitor and target model, all away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
    if (go_req_n != go_ack_n) begin
      go_ack_n = go_req_n;
      start = 1; img_len = LW'(n_img);
      idx = 0; pend = 0; rise_cnt = 0; cap_n = 0; bitc = 0; fin_cnt = 0;
      hi_bad = 0; busy_gap = 0; seen_busy = 0; mid_done = 0; low_w = 0;
    end else if (mid_en && !mid_done && rise_cnt == 5) begin
      start = 1; mid_done = 1; img_len = LW'(9);
    end else begin
      start = 0;
    end
    // monitor
    if (cclk && !cclk_prev) begin
      rise_cnt++;
      shreg = {shreg[6:0], din};
      bitc++;
      if (bitc == 8) begin
        if (cap_n < 16) cap[cap_n] = shreg;
        cap_n++;
        bitc = 0;
      end
      hi_run = 1;
    end else if (cclk) begin
      hi_run++;
    end
    if (!cclk && cclk_prev && hi_run != P_HI) hi_bad++;
    cclk_prev = cclk;
    if (!prog_n) low_run++;
    else if (!prog_prev) begin low_w = low_run; low_run = 0; end
    prog_prev = prog_n;
    if (busy) seen_busy = 1;
    else if (seen_busy && !finish) busy_gap++;
    if (finish) begin fin_cnt++; seen_busy = 0; end
    // target model
    if (!prog_n) begin init_n = 0; icnt = 0; end
    else if (init_dly >= 0) begin
      if (icnt >= init_dly) init_n = 1; else icnt++;
    end else init_n = 0;
    done = (done_extra >= 0) && (rise_cnt >= done_tgt);
    // byte source
    if (pend) begin idx++; pend = 0; end
    src_err = (err_at >= 0) && (idx >= err_at);
    byte_valid = (idx < n_img) && ($urandom_range(3) != 0);
    byte_data = (idx < 16) ? img[idx] : 8'h00;
    pend = byte_valid && byte_ready && !src_err;
  end

  task automatic run_case(input int n, input int err, input int idly,
                          input int extra, input bit mid);
    int exp_b, exp_st, lo_r, hi_r;
    @(posedge clk);
    n_img = n; err_at = err; init_dly = idly; done_extra = extra; mid_en = mid;
    for (int i = 0; i < 16; i++) img[i] = 8'($urandom);
    exp_b = (err >= 0 && err < n) ? err : n;
    if (idly < 0) exp_b = 0;
    done_tgt = exp_b * 8 + extra;
    go_req_n++;
    do begin @(negedge clk); #1; end while (fin_cnt == 0);
    repeat (8) @(negedge clk);
    #1;
    exp_st = (idly < 0) ? 1 : ((extra < 0) ? 2 : 0);
    chk(status == 2'(exp_st), "R6/R7/R8 status", status, exp_st);
    chk(fin_cnt == 1, mid ? "R11 single finish" : "R10 finish count", fin_cnt, 1);
    chk(busy_gap == 0, "R10 busy held until finish", busy_gap, 0);
    chk(idx == exp_b, (err >= 0) ? "R9 accepted bytes" : "R5 accepted bytes", idx, exp_b);
    chk(low_w == P_PROG, "R2 program low width", low_w, P_PROG);
    chk(hi_bad == 0, "R3 clock high width", hi_bad, 0);
    chk(prog_n && !cclk && !din && !busy, "R1 idle pins after run",
        {prog_n, cclk, din, busy}, 4'b1000);
    for (int i = 0; i < exp_b && i < 16; i++)
      chk(cap[i] == img[i], "R4 shifted byte", cap[i], img[i]);
    if (idly < 0) begin
      chk(rise_cnt == 0, "R6 no clock on init timeout", rise_cnt, 0);
    end else if (extra < 0) begin
      chk(rise_cnt == exp_b * 8 + P_DONE, "R8 pulse count at done timeout",
          rise_cnt, exp_b * 8 + P_DONE);
    end else begin
      lo_r = exp_b * 8 + extra; hi_r = lo_r + 1;
      chk(rise_cnt >= lo_r && rise_cnt <= hi_r,
          (n == 0) ? "R12 clocking with zero length" : "R7 done clocking",
          rise_cnt, lo_r);
    end
  endtask

  initial begin
    void'($urandom(32'h1c0fe));
    rst_n = 0;
    repeat (4) @(negedge clk);
    #1;
    chk(prog_n && !cclk && !din && !busy && !finish && status == 2'b00 && !byte_ready,
        "R1 reset state", {prog_n, cclk, din, busy, finish, status}, 7'b1000000);
    rst_n = 1;
    repeat (3) @(negedge clk);
    run_case(3, -1, 10, 4, 0);   // basic image, R4 R5 R7
    run_case(0, -1, 3, 2, 0);    // R12 zero length
    run_case(2, -1, -1, 3, 0);   // R6 init never released
    run_case(2, -1, 5, -1, 0);   // R8 done never rises
    run_case(5, 2, 4, 3, 0);     // R9 source error after two bytes
    run_case(4, -1, 6, 2, 1);    // R11 start during run
    run_case(1, -1, 0, 1, 0);    // single byte, immediate init
    run_case(3, 0, 2, 2, 0);     // R9 error before first byte
    for (int r = 0; r < 6; r++) begin
      run_case(int'($urandom_range(8, 1)), -1, int'($urandom_range(20, 1)),
               int'($urandom_range(5, 1)), 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule